// File: doc/BRIEF.md
# UART DMA Request Pin Generator

This block drives the two active-low DMA request pins of a UART with receive and transmit FIFOs. It watches the transmit FIFO occupancy and full flag, the receive FIFO occupancy, the selected receive trigger level and a receive time-out event. From these it produces a transmit request (`tx_req_n`) and a receive request (`rx_req_n`) that a DMA controller can act on.

Two request policies are supported. In single-character mode the pins follow the FIFOs directly. The transmit request is low while nothing is waiting to be sent. The receive request is low while any character is waiting to be read. In block mode each pin is a held state bit that is set and cleared by events. The transmit pin rises when the FIFO fills and falls when it drains. The receive pin falls when the fill reaches the trigger level or a time-out fires, and it rises only when the FIFO is empty again. Block mode is used only when both the FIFO-enable control and the block-select control are 1. A flush of either FIFO returns its pin to the idle state.

Both pins are registered. Each one reflects the inputs sampled at the previous rising clock edge.

Top module: `uart_dma_ready`

## Requirements
- R1: After synchronous reset, `tx_req_n` is 0 and `rx_req_n` is 1.
- R2: In single-character mode, `tx_req_n` is 0 one cycle after `tx_count` is 0 and 1 one cycle after `tx_count` is nonzero. This holds both with FIFOs disabled and with FIFOs enabled and block-select 0.
- R3: In single-character mode, `rx_req_n` is 0 one cycle after `rx_count` is nonzero and 1 one cycle after `rx_count` is 0.
- R4: Block mode needs `fifo_en`=1 and `dma_sel`=1. With `dma_sel`=1 and `fifo_en`=0, the pins behave as in R2 and R3.
- R5: In block mode, `tx_req_n` becomes 1 one cycle after `tx_full` is 1. It then stays 1 while `tx_count` is nonzero, even after `tx_full` drops, and returns to 0 one cycle after `tx_count` is 0.
- R6: In block mode, when `tx_req_n` is 0, a nonzero `tx_count` without `tx_full` leaves it at 0.
- R7: In block mode, `rx_req_n` becomes 0 one cycle after `rx_count` is at least the trigger level. A nonzero count below the level leaves it at 1.
- R8: In block mode, a one-cycle `rx_timeout` pulse with data present drives `rx_req_n` to 0 on the next cycle, even below the trigger level.
- R9: In block mode, once `rx_req_n` is 0 it stays 0 while `rx_count` is nonzero, including below the trigger level. It returns to 1 one cycle after `rx_count` is 0.
- R10: `trig_sel` values 00, 01, 10 and 11 give trigger levels of 1, 4, 8 and 14 when `wide_fifo`=0, and 1, 16, 32 and 56 when `wide_fifo`=1.
- R11: `tx_flush`=1 gives `tx_req_n`=0 on the next cycle, and `rx_flush`=1 gives `rx_req_n`=1 on the next cycle. Each flush overrides full, trigger and time-out events in the same cycle, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFOs enabled |
| dma_sel | input | 1 | Block request policy select |
| wide_fifo | input | 1 | Selects the 64-entry trigger table |
| trig_sel | input | 2 | Receive trigger level select |
| tx_count | input | CW (7) | Characters held in the transmit FIFO or holding register |
| tx_full | input | 1 | Transmit FIFO full |
| rx_count | input | CW (7) | Characters held in the receive FIFO |
| rx_timeout | input | 1 | Receive time-out event pulse |
| tx_flush | input | 1 | Transmit FIFO reset |
| rx_flush | input | 1 | Receive FIFO reset |
| tx_req_n | output | 1 | Transmit DMA request, active low |
| rx_req_n | output | 1 | Receive DMA request, active low |

## Verification
The block-mode state bits are not visible at the ports. A state bit that is lost or wrongly set only shows up when the FIFO count moves between the set and clear thresholds, where the pin should hold. The directed scenarios therefore drive counts into that middle band right after each set event and right after each clear event. A wrong value then appears on the pin one clock later. Trigger decoding is swept over all eight table entries just below and at the level, so an off-by-one compare or a swapped table shows up on the first wrong entry.

// File: rtl/uart_dmareq_pkg.sv
package uart_dmareq_pkg;

    typedef enum logic {
        POLICY_SINGLE = 1'b0,
        POLICY_BLOCK  = 1'b1
    } req_policy_e;

    // Events presented to a request state bit in one cycle
    typedef struct packed {
        logic flush;   // FIFO reset: back to idle
        logic drain;   // FIFO empty
        logic arm;     // set condition of block policy
    } req_evt_t;

    // Trigger level in characters for a select code
    function automatic int rx_trigger_level(input logic wide, input logic [1:0] sel);
        int lvl;
        unique case (sel)
            2'b00:   lvl = 1;
            2'b01:   lvl = wide ? 16 : 4;
            2'b10:   lvl = wide ? 32 : 8;
            default: lvl = wide ? 56 : 14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/dmareq_policy.sv
module dmareq_policy
    import uart_dmareq_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          fifo_en,
    input  logic          dma_sel,
    input  logic          wide_fifo,
    input  logic [1:0]    trig_sel,
    output req_policy_e   policy,
    output logic [CW-1:0] trig_lvl
);
    // Block policy only when FIFOs are on and block select is set
    always_comb begin
        policy   = (fifo_en && dma_sel) ? POLICY_BLOCK : POLICY_SINGLE;
        trig_lvl = CW'(rx_trigger_level(wide_fifo, trig_sel));
    end

    always_comb begin
        a_r4_block_needs_both: assert (policy != POLICY_BLOCK || (fifo_en && dma_sel));
        a_r10_level_nonzero:   assert (trig_lvl != '0);
    end
endmodule

// File: rtl/dmareq_tx_track.sv
module dmareq_tx_track
    import uart_dmareq_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  req_policy_e   policy,
    input  logic [CW-1:0] tx_count,
    input  logic          tx_full,
    input  logic          tx_flush,
    output logic          tx_req_n
);
    req_evt_t ev;
    logic     nxt;

    always_comb begin
        ev.flush = tx_flush;
        ev.drain = (tx_count == '0);
        ev.arm   = tx_full;
        if (ev.flush || ev.drain)
            nxt = 1'b0;
        else if (policy == POLICY_SINGLE)
            nxt = 1'b1;
        else if (ev.arm)
            nxt = 1'b1;
        else
            nxt = tx_req_n;
    end

    always_ff @(posedge clk) begin
        if (rst) tx_req_n <= 1'b0;
        else     tx_req_n <= nxt;
    end

    a_r11_tx_flush: assert property (@(posedge clk) disable iff (rst)
        tx_flush |=> !tx_req_n);
    a_r5_tx_full_sets: assert property (@(posedge clk) disable iff (rst)
        (policy == POLICY_BLOCK && tx_full && tx_count != '0 && !tx_flush) |=> tx_req_n);
    a_r6_tx_no_early_set: assert property (@(posedge clk) disable iff (rst)
        (policy == POLICY_BLOCK && !tx_req_n && !tx_full) |=> !tx_req_n);
    a_r2_tx_single: assert property (@(posedge clk) disable iff (rst)
        (policy == POLICY_SINGLE && tx_count != '0 && !tx_flush) |=> tx_req_n);
endmodule

// File: rtl/dmareq_rx_track.sv
module dmareq_rx_track
    import uart_dmareq_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  req_policy_e   policy,
    input  logic [CW-1:0] trig_lvl,
    input  logic [CW-1:0] rx_count,
    input  logic          rx_timeout,
    input  logic          rx_flush,
    output logic          rx_req_n
);
    req_evt_t ev;
    logic     nxt;

    always_comb begin
        ev.flush = rx_flush;
        ev.drain = (rx_count == '0);
        ev.arm   = (rx_count >= trig_lvl) || rx_timeout;
        if (ev.flush || ev.drain)
            nxt = 1'b1;
        else if (policy == POLICY_SINGLE)
            nxt = 1'b0;
        else if (ev.arm)
            nxt = 1'b0;
        else
            nxt = rx_req_n;
    end

    always_ff @(posedge clk) begin
        if (rst) rx_req_n <= 1'b1;
        else     rx_req_n <= nxt;
    end

    a_r11_rx_flush: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> rx_req_n);
    a_r9_rx_hold: assert property (@(posedge clk) disable iff (rst)
        (policy == POLICY_BLOCK && !rx_req_n && rx_count != '0 && !rx_flush) |=> !rx_req_n);
    a_r7_rx_trigger: assert property (@(posedge clk) disable iff (rst)
        (policy == POLICY_BLOCK && rx_count >= trig_lvl && rx_count != '0 && !rx_flush)
        |=> !rx_req_n);
    a_r8_rx_timeout: assert property (@(posedge clk) disable iff (rst)
        (policy == POLICY_BLOCK && rx_timeout && rx_count != '0 && !rx_flush) |=> !rx_req_n);
    a_r3_rx_single: assert property (@(posedge clk) disable iff (rst)
        (policy == POLICY_SINGLE && rx_count != '0 && !rx_flush) |=> !rx_req_n);
endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready
    import uart_dmareq_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic          dma_sel,
    input  logic          wide_fifo,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] tx_count,
    input  logic          tx_full,
    input  logic [CW-1:0] rx_count,
    input  logic          rx_timeout,
    input  logic          tx_flush,
    input  logic          rx_flush,
    output logic          tx_req_n,
    output logic          rx_req_n
);
    req_policy_e   policy;
    logic [CW-1:0] trig_lvl;

    dmareq_policy #(.CW(CW)) u_policy (
        .fifo_en   (fifo_en),
        .dma_sel   (dma_sel),
        .wide_fifo (wide_fifo),
        .trig_sel  (trig_sel),
        .policy    (policy),
        .trig_lvl  (trig_lvl)
    );

    dmareq_tx_track #(.CW(CW)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .policy   (policy),
        .tx_count (tx_count),
        .tx_full  (tx_full),
        .tx_flush (tx_flush),
        .tx_req_n (tx_req_n)
    );

    dmareq_rx_track #(.CW(CW)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .policy     (policy),
        .trig_lvl   (trig_lvl),
        .rx_count   (rx_count),
        .rx_timeout (rx_timeout),
        .rx_flush   (rx_flush),
        .rx_req_n   (rx_req_n)
    );

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!tx_req_n && rx_req_n));
endmodule

// File: tb/tb_uart_dma_ready.sv
module tb_uart_dma_ready;
    localparam int CW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fifo_en = 1'b0, dma_sel = 1'b0, wide_fifo = 1'b0;
    logic [1:0]    trig_sel = 2'b00;
    logic [CW-1:0] tx_count = '0, rx_count = '0;
    logic          tx_full = 1'b0, rx_timeout = 1'b0, tx_flush = 1'b0, rx_flush = 1'b0;
    logic          tx_req_n, rx_req_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    uart_dma_ready dut (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_sel(dma_sel),
        .wide_fifo(wide_fifo), .trig_sel(trig_sel), .tx_count(tx_count),
        .tx_full(tx_full), .rx_count(rx_count), .rx_timeout(rx_timeout),
        .tx_flush(tx_flush), .rx_flush(rx_flush),
        .tx_req_n(tx_req_n), .rx_req_n(rx_req_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // apply inputs at a falling edge, let one rising edge pass, return at next falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_mode(input logic fe, input logic ds);
        fifo_en = fe; dma_sel = ds;
    endtask

    task automatic t_reset();
        chk("R1 tx", tx_req_n, 1'b0);
        chk("R1 rx", rx_req_n, 1'b1);
    endtask

    task automatic t_single_tx();
        for (int m = 0; m < 2; m++) begin
            set_mode(m[0], 1'b0);
            tx_count = 0;  step(); chk("R2 tx empty", tx_req_n, 1'b0);
            tx_count = 3;  step(); chk("R2 tx data", tx_req_n, 1'b1);
            tx_count = 1;  step(); chk("R2 tx data", tx_req_n, 1'b1);
            tx_count = 0;  step(); chk("R2 tx drained", tx_req_n, 1'b0);
        end
    endtask

    task automatic t_single_rx();
        set_mode(1'b1, 1'b0); trig_sel = 2'b11;
        rx_count = 1;  step(); chk("R3 rx data", rx_req_n, 1'b0);
        rx_count = 5;  step(); chk("R3 rx data", rx_req_n, 1'b0);
        rx_count = 0;  step(); chk("R3 rx empty", rx_req_n, 1'b1);
    endtask

    task automatic t_needs_fifo();
        set_mode(1'b0, 1'b1); trig_sel = 2'b11;
        tx_count = 5;  step(); chk("R4 tx single", tx_req_n, 1'b1);
        rx_count = 2;  step(); chk("R4 rx single", rx_req_n, 1'b0);
        tx_count = 0; rx_count = 0; step();
        chk("R4 tx idle", tx_req_n, 1'b0);
        chk("R4 rx idle", rx_req_n, 1'b1);
    endtask

    task automatic t_block_tx();
        set_mode(1'b1, 1'b1);
        tx_count = 0;  step(); chk("R5 tx start", tx_req_n, 1'b0);
        tx_count = 10; step(); chk("R6 tx partial", tx_req_n, 1'b0);
        tx_count = 63; step(); chk("R6 tx near full", tx_req_n, 1'b0);
        tx_count = 64; tx_full = 1; step(); chk("R5 tx full set", tx_req_n, 1'b1);
        tx_count = 30; tx_full = 0; step(); chk("R5 tx hold", tx_req_n, 1'b1);
        tx_count = 1;  step(); chk("R5 tx hold low", tx_req_n, 1'b1);
        tx_count = 0;  step(); chk("R5 tx drained", tx_req_n, 1'b0);
        tx_count = 20; step(); chk("R6 tx refill", tx_req_n, 1'b0);
        tx_count = 0;  step();
    endtask

    task automatic t_block_rx();
        set_mode(1'b1, 1'b1); wide_fifo = 0; trig_sel = 2'b10;   // level 8
        rx_count = 5;  step(); chk("R7 rx below", rx_req_n, 1'b1);
        rx_count = 8;  step(); chk("R7 rx at level", rx_req_n, 1'b0);
        rx_count = 3;  step(); chk("R9 rx hold", rx_req_n, 1'b0);
        rx_count = 0;  step(); chk("R9 rx drained", rx_req_n, 1'b1);
        rx_count = 7;  step(); chk("R9 rx stays off", rx_req_n, 1'b1);
        rx_count = 0;  step();
    endtask

    task automatic t_timeout();
        set_mode(1'b1, 1'b1); wide_fifo = 1; trig_sel = 2'b11;   // level 56
        rx_count = 2;  step(); chk("R8 rx below", rx_req_n, 1'b1);
        rx_timeout = 1; step(); chk("R8 rx timeout", rx_req_n, 1'b0);
        rx_timeout = 0; step(); chk("R8 rx held", rx_req_n, 1'b0);
        rx_count = 0;  step(); chk("R8 rx drained", rx_req_n, 1'b1);
    endtask

    task automatic t_levels();
        int narrow [4] = '{1, 4, 8, 14};
        int deep   [4] = '{1, 16, 32, 56};
        set_mode(1'b1, 1'b1);
        for (int w = 0; w < 2; w++) begin
            for (int s = 0; s < 4; s++) begin
                int lvl;
                lvl = (w == 1) ? deep[s] : narrow[s];
                wide_fifo = w[0]; trig_sel = s[1:0];
                if (lvl > 1) begin
                    rx_count = CW'(lvl - 1); step();
                    chk("R10 below level", rx_req_n, 1'b1);
                end
                rx_count = CW'(lvl); step(); chk("R10 at level", rx_req_n, 1'b0);
                rx_count = 0; step(); chk("R10 reset", rx_req_n, 1'b1);
            end
        end
    endtask

    task automatic t_flush();
        set_mode(1'b1, 1'b1); wide_fifo = 0; trig_sel = 2'b00;
        tx_count = 64; tx_full = 1; step(); chk("R11 tx pre", tx_req_n, 1'b1);
        tx_flush = 1; step(); chk("R11 tx flush", tx_req_n, 1'b0);
        tx_flush = 0; tx_count = 0; tx_full = 0; step();
        rx_count = 20; step(); chk("R11 rx pre", rx_req_n, 1'b0);
        rx_flush = 1; rx_timeout = 1; step(); chk("R11 rx flush", rx_req_n, 1'b1);
        rx_flush = 0; rx_timeout = 0; rx_count = 0; step();
        set_mode(1'b1, 1'b0);
        rx_count = 4; rx_flush = 1; step(); chk("R11 rx flush single", rx_req_n, 1'b1);
        rx_flush = 0; rx_count = 0; step();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single_tx();
        t_single_rx();
        t_needs_fifo();
        t_block_tx();
        t_block_rx();
        t_timeout();
        t_levels();
        t_flush();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got running expected finished");
            finish_run();
        end
    end
endmodule